// File: doc/BRIEF.md
# Radix-4 Non-Redundant Signed-Digit Coefficient Encoder

This combinational block converts an n-bit two's-complement coefficient (n even, n = 2k) into a compact radix-4 signed-digit code. The code is written once into a coefficient memory and later drives a partial-product generator, which sees one digit per pair of coefficient bits. A single mode input picks between two digit alphabets. The negative-biased alphabet is {-2,-1,0,+1} and the positive-biased alphabet is {-1,0,+1,+2}.

The k-1 lower digits each need only two stored bits. A carry ripples upward from the least significant bit pair. Each pair passes through a plain half adder and a modified half adder, and the mode sets the order of the two. The carry that leaves the last low pair joins the two top coefficient bits to form a Booth-style digit in {-2..+2}. That digit is stored as a sign/two/one triple so the full two's-complement range stays covered. The whole code is n+1 bits wide.

Top module: `nrsd_encoder`

## Requirements
- R1: `code_o` is N+1 bits wide. Low digit j (0 <= j <= N/2-2) occupies bits [2j+1:2j] as {hi, lo}. The top digit occupies bits [N:N-2] as {sign, two, one}.
- R2: With `mode_i` = 0 (negative-biased), low digit j has value -2*hi + lo.
- R3: With `mode_i` = 1 (positive-biased), low digit j has value 2*hi - lo.
- R4: Each low digit is the unique member of the selected alphabet that is congruent modulo 4 to the part of the coefficient not yet absorbed by lower digits. In particular, digit 0 is congruent to `coef_i[1:0]` modulo 4.
- R5: The top digit has value (sign ? -1 : +1) * (2*two + one). `one` and `two` are never both set. The magnitude lies in 0..2.
- R6: For every coefficient and both modes, the sum of all digits weighted by 4^j equals the signed value of `coef_i`.
- R7: A zero coefficient produces an all-zero code in both modes.
- R8: The most negative coefficient gives all-zero low digits and a top digit of -2. The most positive coefficient gives a top digit of +2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_i | input | 1 | Alphabet select: 0 negative-biased, 1 positive-biased |
| coef_i | input | N | Two's-complement coefficient |
| code_o | output | N+1 | Encoded digits: low pairs, then the top sign/two/one triple |

## Verification
The bench sweeps every 8-bit coefficient in both modes. It compares each low pair against digits derived arithmetically by repeated modulo-4 reduction, so a swapped AND/OR in either half-adder stage shows up as wrong pair bits even where the weighted total happens to survive. The two extremes of the range are checked separately: a top digit that drops the carry from the chain, or that mishandles the magnitude-two case, yields +/-1 or 0 where +/-2 is required. The zero coefficient and the -1 coefficient exercise the carry chain's start value. A nonzero start value would leave a spurious digit in pair 0.

// File: rtl/nrsd_pkg.sv
package nrsd_pkg;

  // Alphabet selection carried on mode_i
  typedef enum logic {
    NRSD_NEG_BIASED = 1'b0,
    NRSD_POS_BIASED = 1'b1
  } nrsd_mode_e;

  // Field positions inside the top-digit triple
  localparam int unsigned TOP_ONE_BIT  = 0;
  localparam int unsigned TOP_TWO_BIT  = 1;
  localparam int unsigned TOP_SIGN_BIT = 2;
  localparam int unsigned TOP_WIDTH    = 3;
  localparam int unsigned PAIR_WIDTH   = 2;

endpackage

// File: rtl/nrsd_ha.sv
// Half-adder cell whose carry is either AND (plain) or OR (modified).
// The sum is the XOR in both forms.
module nrsd_ha (
  input  logic use_or_i,
  input  logic a_i,
  input  logic c_i,
  output logic co_o,
  output logic s_o
);

  always_comb begin
    s_o  = a_i ^ c_i;
    co_o = use_or_i ? (a_i | c_i) : (a_i & c_i);
  end

endmodule

// File: rtl/nrsd_digit.sv
// One low digit: an even-bit stage followed by an odd-bit stage.
// Negative-biased: plain then modified. Positive-biased: modified then plain.
module nrsd_digit
  import nrsd_pkg::*;
(
  input  logic                  mode_i,
  input  logic [PAIR_WIDTH-1:0] bits_i,
  input  logic                  cin_i,
  output logic [PAIR_WIDTH-1:0] pair_o,
  output logic                  cout_o
);

  logic even_or;
  logic odd_or;
  logic mid_carry;
  logic even_sum;
  logic odd_sum;

  always_comb begin
    even_or = (mode_i == NRSD_POS_BIASED);
    odd_or  = (mode_i == NRSD_NEG_BIASED);
  end

  nrsd_ha u_even (
    .use_or_i (even_or),
    .a_i      (bits_i[0]),
    .c_i      (cin_i),
    .co_o     (mid_carry),
    .s_o      (even_sum)
  );

  nrsd_ha u_odd (
    .use_or_i (odd_or),
    .a_i      (bits_i[1]),
    .c_i      (mid_carry),
    .co_o     (cout_o),
    .s_o      (odd_sum)
  );

  assign pair_o = {odd_sum, even_sum};

endmodule

// File: rtl/nrsd_top_digit.sv
// Booth-style top digit from two coefficient bits and the incoming chain carry.
// Value = -2*hi + lo + cin, emitted as {sign, two, one}.
module nrsd_top_digit
  import nrsd_pkg::*;
(
  input  logic                 hi_i,
  input  logic                 lo_i,
  input  logic                 cin_i,
  output logic [TOP_WIDTH-1:0] triple_o
);

  logic mag_one;
  logic mag_two;

  always_comb begin
    mag_one = lo_i ^ cin_i;
    mag_two = (hi_i & ~lo_i & ~cin_i) | (~hi_i & lo_i & cin_i);
    triple_o               = '0;
    triple_o[TOP_SIGN_BIT] = hi_i;
    triple_o[TOP_TWO_BIT]  = mag_two;
    triple_o[TOP_ONE_BIT]  = mag_one;
  end

endmodule

// File: rtl/nrsd_encoder.sv
module nrsd_encoder
  import nrsd_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic         mode_i,
  input  logic [N-1:0] coef_i,
  output logic [N:0]   code_o
);

  localparam int unsigned K       = N / 2;
  localparam int unsigned LOW_CNT = K - 1;
  localparam int unsigned LOW_W   = PAIR_WIDTH * LOW_CNT;

  // carry[j] enters low digit j; carry[LOW_CNT] feeds the top digit
  logic [LOW_CNT:0]     carry;
  logic [LOW_W-1:0]     low_code;
  logic [TOP_WIDTH-1:0] top_code;

  assign carry[0] = 1'b0;

  for (genvar j = 0; j < LOW_CNT; j++) begin : g_low
    nrsd_digit u_digit (
      .mode_i (mode_i),
      .bits_i (coef_i[PAIR_WIDTH*j +: PAIR_WIDTH]),
      .cin_i  (carry[j]),
      .pair_o (low_code[PAIR_WIDTH*j +: PAIR_WIDTH]),
      .cout_o (carry[j+1])
    );
  end

  nrsd_top_digit u_top (
    .hi_i     (coef_i[N-1]),
    .lo_i     (coef_i[N-2]),
    .cin_i    (carry[LOW_CNT]),
    .triple_o (top_code)
  );

  assign code_o = {top_code, low_code};

endmodule

// File: rtl/nrsd_encoder_chk.sv
module nrsd_encoder_chk
  import nrsd_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input logic         mode_i,
  input logic [N-1:0] coef_i,
  input logic [N:0]   code_o
);

  localparam int unsigned LOW_CNT = N / 2 - 1;

  function automatic int pair_value(input logic m, input logic hi, input logic lo);
    int h;
    int l;
    h = int'(hi);
    l = int'(lo);
    return m ? (2 * h - l) : (l - 2 * h);
  endfunction

  function automatic int decode(input logic m, input logic [N:0] code);
    int total;
    int top;
    total = 0;
    for (int j = 0; j < LOW_CNT; j++) begin
      total += pair_value(m, code[2*j+1], code[2*j]) * (1 << (2*j));
    end
    top = 2 * int'(code[N-2+TOP_TWO_BIT]) + int'(code[N-2+TOP_ONE_BIT]);
    if (code[N-2+TOP_SIGN_BIT]) top = -top;
    total += top * (1 << (2*LOW_CNT));
    return total;
  endfunction

  int coef_val;
  int digit0;

  always_comb begin
    coef_val = int'($signed(coef_i));
    digit0   = pair_value(mode_i, code_o[1], code_o[0]);

    // R6: weighted digits reconstruct the coefficient
    a_r6_value_match: assert (decode(mode_i, code_o) == coef_val);

    // R5: top digit never flags both magnitudes
    a_r5_top_flags_exclusive:
      assert (!(code_o[N-2+TOP_ONE_BIT] && code_o[N-2+TOP_TWO_BIT]));

    // R4: lowest digit congruent to the two lowest coefficient bits
    a_r4_low_residue:
      assert (((digit0 - int'(coef_i[1:0])) & 3) == 0);

    // R7: zero coefficient yields an all-zero code
    if (coef_i == '0) begin
      a_r7_zero_code: assert (code_o == '0);
    end
  end

endmodule

bind nrsd_encoder nrsd_encoder_chk #(.N(N)) u_chk (
  .mode_i (mode_i),
  .coef_i (coef_i),
  .code_o (code_o)
);

// File: tb/nrsd_encoder_test.sv
module nrsd_encoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 8;
  localparam int LOW_CNT    = N / 2 - 1;

  logic         clk;
  logic         rst_n;
  logic         mode_i;
  logic [N-1:0] coef_i;
  logic [N:0]   code_o;

  int compared;
  int mismatched;
  bit finished;

  nrsd_encoder #(.N(N)) uut (
    .mode_i (mode_i),
    .coef_i (coef_i),
    .code_o (code_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected digits by repeated modulo-4 reduction (R4)
  task automatic expect_digits(input bit m, input int x, output int d[LOW_CNT], output int top);
    int r;
    int rem;
    rem = x;
    for (int j = 0; j < LOW_CNT; j++) begin
      r = rem & 3;
      if (m) d[j] = (r == 3) ? -1 : r;
      else   d[j] = (r == 3) ? -1 : (r == 2) ? -2 : r;
      rem = (rem - d[j]) >>> 2;
    end
    top = rem;
  endtask

  function automatic int low_val(input bit m, input logic hi, input logic lo);
    return m ? (2 * int'(hi) - int'(lo)) : (int'(lo) - 2 * int'(hi));
  endfunction

  function automatic int top_val(input logic [N:0] c);
    int t;
    t = 2 * int'(c[N-1]) + int'(c[N-2]);
    return c[N] ? -t : t;
  endfunction

  task automatic apply(input bit m, input int x);
    @(negedge clk);
    mode_i = m;
    coef_i = x[N-1:0];
    #1;
  endtask

  task automatic check_full(input bit m, input int x);
    int d[LOW_CNT];
    int top;
    int sum;
    logic [2*LOW_CNT-1:0] exp_low;
    expect_digits(m, x, d, top);
    sum = 0;
    for (int j = 0; j < LOW_CNT; j++) begin
      exp_low[2*j+1] = m ? (d[j] > 0) : (d[j] < 0);
      exp_low[2*j]   = (d[j] == 1) || (d[j] == -1);
      sum += low_val(m, code_o[2*j+1], code_o[2*j]) * (1 << (2*j));
    end
    sum += top_val(code_o) * (1 << (2*LOW_CNT));
    // R1 R2 R3 R4: low pair bits in position
    check(code_o[2*LOW_CNT-1:0] == exp_low, m ? "R3" : "R2",
          int'(code_o[2*LOW_CNT-1:0]), int'(exp_low));
    // R5: top digit value and exclusive flags
    check((top_val(code_o) == top) && !(code_o[N-1] && code_o[N-2]), "R5",
          top_val(code_o), top);
    // R6: reconstruction
    check(sum == x, "R6", sum, x);
  endtask

  task automatic t_zero();
    for (int m = 0; m < 2; m++) begin
      apply(m[0], 0);
      check(code_o == '0, "R7", int'(code_o), 0); // R7
    end
  endtask

  task automatic t_minus_one();
    // carry chain start: -1 must give digit 0 = -1, everything else 0
    for (int m = 0; m < 2; m++) begin
      apply(m[0], -1);
      check(low_val(m[0], code_o[1], code_o[0]) == -1, "R4",
            low_val(m[0], code_o[1], code_o[0]), -1);
      check(top_val(code_o) == 0, "R5", top_val(code_o), 0);
    end
  endtask

  task automatic t_extremes();
    int lo_lim;
    int hi_lim;
    lo_lim = -(1 << (N-1));
    hi_lim = (1 << (N-1)) - 1;
    for (int m = 0; m < 2; m++) begin
      apply(m[0], lo_lim);
      check(code_o[2*LOW_CNT-1:0] == '0, "R8", int'(code_o[2*LOW_CNT-1:0]), 0);
      check(top_val(code_o) == -2, "R8", top_val(code_o), -2);
      apply(m[0], hi_lim);
      check(top_val(code_o) == 2, "R8", top_val(code_o), 2);
      check_full(m[0], hi_lim);
    end
  endtask

  task automatic t_sweep(input bit m);
    for (int x = -(1 << (N-1)); x < (1 << (N-1)); x++) begin
      apply(m, x);
      check_full(m, x);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    compared   = 0;
    mismatched = 0;
    finished   = 1'b0;
    rst_n      = 1'b0;
    mode_i     = 1'b0;
    coef_i     = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_zero();
    t_minus_one();
    t_extremes();
    t_sweep(1'b0);
    t_sweep(1'b1);
    finish_run();
  end

endmodule